// File: doc/BRIEF.md
# Dual Byte FIFO With Radio Status Count

This block holds the two byte queues that sit between a serial host link and a sub-GHz radio datapath. One queue carries bytes from the host towards the transmitter; the other carries bytes from the receiver towards the host. The host works at byte level. It lowers a select line and delivers a header byte. A header whose low six bits are all ones opens a queue access, and the top bit picks the direction. Data bytes follow, either one per header or as a stream that lasts until the select line rises. With every accepted byte the block returns a saturating 4-bit count that tells the host how much room or how much data it may rely on.

The radio side pops bytes from the transmit queue and pushes bytes into the receive queue. A pop from an empty transmit queue, or a push into a full receive queue, raises a one-cycle event. The surrounding state controller uses these events to stop the radio and enter its matching error state. That controller reports its 3-bit state back to the block, which uses it to decide whether flush requests are honoured. Entry into sleep empties both queues.

Top module: `radio_fifo_pair`

## Requirements
- R1: Only headers whose bits [5:0] equal 6'h3F open a queue access. Bit 7 selects the direction (0 writes the transmit queue, 1 reads the receive queue), so 0x3F/0x7F write and 0xBF/0xFF read. Any other header, and any byte sent while `cs_n` is high, leaves both queues unchanged.
- R2: When bit 6 of the header is 0, exactly one data byte follows and the next byte is taken as a new header. When bit 6 is 1, every following byte is data until `cs_n` rises.
- R3: One cycle after each accepted byte, `status_cnt` shows a count taken before that byte acts. The count is the receive bytes available for a read header or a read data byte, and the transmit bytes free for any other byte.
- R4: `status_cnt` saturates at 15. Writing a queue of DEPTH bytes returns 15 down to 1, and the final byte that fits returns 1.
- R5: A write to a full transmit queue is dropped, and its status shows 0.
- R6: A read from an empty receive queue moves no pointer, and `rd_data` keeps the last byte read.
- R7: Both queues are first-in first-out. `tx_data` shows the oldest transmit byte, and `rd_data` is updated one cycle after a read data byte.
- R8: `tx_pop` while `tx_empty` is 1 raises `underflow_evt` for the following cycle, and the queue stays unchanged.
- R9: `rx_push` while `rx_full` is 1 raises `overflow_evt` for the following cycle, and the pushed byte is lost.
- R10: `flush_tx` and `flush_rx` empty their queue at the next edge only when `radio_state` is 0 (idle), 6 (receive overflow) or 7 (transmit underflow). In states 1 to 5 they have no effect.
- R11: A rising edge of `radio_sleep` empties both queues at the next edge.
- R12: After reset both queues are empty, `status_cnt` and `rd_data` are 0, and neither event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low; a rise ends any access |
| byte_valid | input | 1 | A host byte is presented this cycle |
| byte_in | input | 8 | Host header or data byte |
| status_cnt | output | 4 | Saturated available/free count for the last byte |
| rd_data | output | 8 | Last byte read from the receive queue |
| radio_state | input | 3 | Current controller state code |
| radio_sleep | input | 1 | High while the radio is asleep |
| flush_tx | input | 1 | Flush request for the transmit queue |
| flush_rx | input | 1 | Flush request for the receive queue |
| tx_pop | input | 1 | Radio takes the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Radio stores a received byte |
| rx_data | input | 8 | Received byte to store |
| rx_full | output | 1 | Receive queue full |
| underflow_evt | output | 1 | Pop from an empty transmit queue last cycle |
| overflow_evt | output | 1 | Push into a full receive queue last cycle |

## Verification
The hardest cases to reach are the two queue boundaries on the host side: the final byte that fits, the byte written after it, and the read from an empty queue. Each appears only after a complete 64-byte burst through the byte interface, so the stimulus streams full bursts and predicts every returned count as min(15, room). The flush gate depends on the controller state, so the stimulus sweeps all eight state codes. For each code it preloads one byte into each queue, then looks at `tx_empty` and at the read count to see whether the flush took effect.

// File: rtl/radio_fifo_pkg.sv
package radio_fifo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RX     = 3'd1,
    ST_TX     = 3'd2,
    ST_FSON   = 3'd3,
    ST_CAL    = 3'd4,
    ST_SETTLE = 3'd5,
    ST_RXOVF  = 3'd6,
    ST_TXUNF  = 3'd7
  } radio_state_e;

  localparam logic [5:0] QUEUE_ADDR = 6'h3F;
  localparam int unsigned CNT_MAX = 15;

  function automatic logic flush_allowed(input radio_state_e st);
    return (st == ST_IDLE) || (st == ST_RXOVF) || (st == ST_TXUNF);
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0]    cnt_nxt;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign head    = mem[rd_ptr];
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = count;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (do_push) wr_ptr_nxt = bump(wr_ptr);
      if (do_pop)  rd_ptr_nxt = bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_nxt = count + CW'(1);
        2'b01:   cnt_nxt = count - CW'(1);
        default: cnt_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import radio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [7:0]    rx_head,
  output logic          tx_push,
  output logic          rx_pop,
  output logic [3:0]    status_cnt,
  output logic [7:0]    rd_data
);

  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_e;

  phase_e      phase, phase_nxt;
  logic        dir_rd, dir_rd_nxt;
  logic        burst, burst_nxt;
  logic [3:0]  stat_nxt;
  logic [7:0]  rd_nxt;
  logic        take, cnt_rd;
  logic [CW-1:0] tx_free, sel_cnt;

  assign take    = byte_valid && !cs_n;
  assign tx_free = CW'(DEPTH) - tx_count;
  assign cnt_rd  = (phase == PH_HDR) ? byte_in[7] : dir_rd;
  assign sel_cnt = cnt_rd ? rx_count : tx_free;
  assign tx_push = take && (phase == PH_DATA) && !dir_rd;
  assign rx_pop  = take && (phase == PH_DATA) && dir_rd;

  always_comb begin
    phase_nxt  = phase;
    dir_rd_nxt = dir_rd;
    burst_nxt  = burst;
    stat_nxt   = status_cnt;
    rd_nxt     = rd_data;
    if (cs_n) begin
      phase_nxt = PH_HDR;
    end else if (take) begin
      stat_nxt = (sel_cnt >= CW'(CNT_MAX)) ? 4'(CNT_MAX) : sel_cnt[3:0];
      if (phase == PH_HDR) begin
        if (byte_in[5:0] == QUEUE_ADDR) begin
          phase_nxt  = PH_DATA;
          dir_rd_nxt = byte_in[7];
          burst_nxt  = byte_in[6];
        end
      end else begin
        if (!burst) phase_nxt = PH_HDR;
        if (dir_rd && (rx_count != '0)) rd_nxt = rx_head;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_HDR;
      dir_rd     <= 1'b0;
      burst      <= 1'b0;
      status_cnt <= '0;
      rd_data    <= '0;
    end else begin
      phase      <= phase_nxt;
      dir_rd     <= dir_rd_nxt;
      burst      <= burst_nxt;
      status_cnt <= stat_nxt;
      rd_data    <= rd_nxt;
    end
  end

endmodule

// File: rtl/radio_fifo_pair.sv
module radio_fifo_pair
  import radio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic [3:0] status_cnt,
  output logic [7:0] rd_data,
  input  logic [2:0] radio_state,
  input  logic       radio_sleep,
  input  logic       flush_tx,
  input  logic       flush_rx,
  input  logic       tx_pop,
  output logic [7:0] tx_data,
  output logic       tx_empty,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  output logic       rx_full,
  output logic       underflow_evt,
  output logic       overflow_evt
);

  logic [CW-1:0] tx_count, rx_count;
  logic [7:0]    rx_head;
  logic          tx_full_unused, rx_empty_unused;
  logic          host_tx_push, host_rx_pop;
  logic          sleep_q, sleep_enter, gate_ok;
  logic          clr_tx, clr_rx;
  logic          unf_nxt, ovf_nxt;

  assign sleep_enter = radio_sleep && !sleep_q;
  assign gate_ok     = flush_allowed(radio_state_e'(radio_state));
  assign clr_tx      = sleep_enter || (flush_tx && gate_ok);
  assign clr_rx      = sleep_enter || (flush_rx && gate_ok);
  assign unf_nxt     = tx_pop && tx_empty;
  assign ovf_nxt     = rx_push && rx_full;

  host_byte_port #(.DEPTH(DEPTH)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .rx_head    (rx_head),
    .tx_push    (host_tx_push),
    .rx_pop     (host_rx_pop),
    .status_cnt (status_cnt),
    .rd_data    (rd_data)
  );

  byte_queue #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_tx),
    .push  (host_tx_push),
    .wdata (byte_in),
    .pop   (tx_pop),
    .head  (tx_data),
    .count (tx_count),
    .full  (tx_full_unused),
    .empty (tx_empty)
  );

  byte_queue #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_rx),
    .push  (rx_push),
    .wdata (rx_data),
    .pop   (host_rx_pop),
    .head  (rx_head),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q       <= 1'b0;
      underflow_evt <= 1'b0;
      overflow_evt  <= 1'b0;
    end else begin
      sleep_q       <= radio_sleep;
      underflow_evt <= unf_nxt;
      overflow_evt  <= ovf_nxt;
    end
  end

endmodule

// File: rtl/radio_fifo_pair_chk.sv
module radio_fifo_pair_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    radio_state,
  input logic          radio_sleep,
  input logic          flush_tx,
  input logic          flush_rx,
  input logic          tx_pop,
  input logic          tx_empty,
  input logic          rx_push,
  input logic          rx_full,
  input logic          underflow_evt,
  input logic          overflow_evt,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);

  logic st_ok;
  assign st_ok = (radio_state == 3'd0) || (radio_state == 3'd6) || (radio_state == 3'd7);

  p_underflow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |-> $past(tx_pop && tx_empty));

  p_underflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_empty && !radio_sleep) |=> (tx_count == '0));

  p_overflow_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |-> $past(rx_push && rx_full));

  p_overflow_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  p_flush_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx && st_ok) |=> tx_empty);

  p_flush_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rx && st_ok) |=> (rx_count == '0));

  p_sleep_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(radio_sleep) |=> (tx_count == '0 && rx_count == '0));

endmodule

bind radio_fifo_pair radio_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .radio_state   (radio_state),
  .radio_sleep   (radio_sleep),
  .flush_tx      (flush_tx),
  .flush_rx      (flush_rx),
  .tx_pop        (tx_pop),
  .tx_empty      (tx_empty),
  .rx_push       (rx_push),
  .rx_full       (rx_full),
  .underflow_evt (underflow_evt),
  .overflow_evt  (overflow_evt),
  .tx_count      (tx_count),
  .rx_count      (rx_count)
);

// File: tb/tb_radio_fifo_pair.sv
`timescale 1ns/1ps
module tb_radio_fifo_pair;

  localparam int DEPTH = 64;

  logic       clk, rst_n, cs_n, byte_valid;
  logic [7:0] byte_in, rd_data, tx_data, rx_data;
  logic [3:0] status_cnt;
  logic [2:0] radio_state;
  logic       radio_sleep, flush_tx, flush_rx, tx_pop, tx_empty, rx_push, rx_full;
  logic       underflow_evt, overflow_evt;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  radio_fifo_pair #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .status_cnt(status_cnt), .rd_data(rd_data), .radio_state(radio_state),
    .radio_sleep(radio_sleep), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .rx_push(rx_push),
    .rx_data(rx_data), .rx_full(rx_full), .underflow_evt(underflow_evt),
    .overflow_evt(overflow_evt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic sel(input logic v);
    @(negedge clk);
    cs_n = v;
  endtask

  task automatic radio_push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1;
    rx_data = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic radio_pop();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; byte_valid = 1'b0; byte_in = '0;
    radio_state = 3'd0; radio_sleep = 1'b0; flush_tx = 1'b0; flush_rx = 1'b0;
    tx_pop = 1'b0; rx_push = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 status", status_cnt, 0);
    check("R12 rd_data", rd_data, 0);
    check("R12 tx_empty", tx_empty, 1);
    check("R12 rx_full", rx_full, 0);
    check("R12 events", {underflow_evt, overflow_evt}, 0);

    // R3/R4/R5 burst write to fill, free count before each byte
    sel(1'b0);
    put(8'h7F);
    check("R3 write header free", status_cnt, 15);
    for (int i = 0; i < DEPTH; i++) begin
      put(8'(i) ^ 8'hA5);
      check("R4 free before byte", status_cnt, sat(DEPTH - i));
    end
    put(8'hEE);
    check("R5 full write status", status_cnt, 0);
    sel(1'b1);

    // R7 drain in order; R5 extra byte dropped
    @(negedge clk);
    tx_pop = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check("R7 tx order", tx_data, int'(8'(i) ^ 8'hA5));
      @(negedge clk);
    end
    tx_pop = 1'b0;
    check("R5 dropped byte absent", tx_empty, 1);
    check("R8 no event while draining", underflow_evt, 0);

    // R8 underflow
    radio_pop();
    check("R8 underflow raised", underflow_evt, 1);
    @(negedge clk);
    check("R8 underflow one cycle", underflow_evt, 0);
    check("R8 queue still empty", tx_empty, 1);

    // R9 receive fill and overflow
    for (int i = 0; i < DEPTH; i++) radio_push(8'(i * 3 + 1));
    check("R9 rx full", rx_full, 1);
    check("R9 no early overflow", overflow_evt, 0);
    @(negedge clk);
    rx_push = 1'b1; rx_data = 8'h99;
    @(negedge clk);
    rx_push = 1'b0;
    check("R9 overflow raised", overflow_evt, 1);

    // R3/R4/R7 burst read, R6 empty read holds last byte
    sel(1'b0);
    put(8'hFF);
    check("R3 read header avail", status_cnt, 15);
    for (int i = 0; i < DEPTH; i++) begin
      put(8'h00);
      check("R7 rx order", rd_data, (i * 3 + 1) & 255);
      check("R4 avail before byte", status_cnt, sat(DEPTH - i));
    end
    put(8'h00);
    check("R6 empty read holds", rd_data, (63 * 3 + 1) & 255);
    check("R6 empty read status", status_cnt, 0);
    sel(1'b1);

    // R2 single access returns to header phase
    sel(1'b0);
    put(8'h3F);
    put(8'h11);
    put(8'hBF);
    check("R2 next byte is read header", status_cnt, 0);
    put(8'h55);
    check("R6 rd_data kept", rd_data, (63 * 3 + 1) & 255);
    sel(1'b1);
    check("R2 single write stored", tx_data, 8'h11);
    radio_pop();
    check("R2 only one byte stored", tx_empty, 1);

    // R1 non-queue headers and bytes with cs_n high
    sel(1'b0);
    put(8'h05);
    put(8'h12);
    put(8'h45);
    sel(1'b1);
    put(8'h3F);
    put(8'h22);
    check("R1 no queue effect", tx_empty, 1);

    // R2 burst ended by cs_n rise
    sel(1'b0);
    put(8'h7F);
    put(8'h01);
    sel(1'b1);
    sel(1'b0);
    put(8'h02);
    sel(1'b1);
    check("R2 burst first byte", tx_data, 1);
    radio_pop();
    check("R2 burst closed", tx_empty, 1);

    // R10 flush gating sweep over all states
    for (int s = 0; s < 8; s++) begin
      automatic int ok = (s == 0 || s == 6 || s == 7) ? 1 : 0;
      radio_state = 3'(s);
      sel(1'b0); put(8'h3F); put(8'h77); sel(1'b1);
      radio_push(8'h66);
      @(negedge clk);
      flush_tx = 1'b1; flush_rx = 1'b1;
      @(negedge clk);
      flush_tx = 1'b0; flush_rx = 1'b0;
      check("R10 tx flush gate", tx_empty, ok);
      sel(1'b0); put(8'hBF);
      check("R10 rx flush gate", status_cnt, 1 - ok);
      sel(1'b1);
      radio_state = 3'd0;
      @(negedge clk);
      flush_tx = 1'b1; flush_rx = 1'b1;
      @(negedge clk);
      flush_tx = 1'b0; flush_rx = 1'b0;
    end

    // R11 sleep entry clears both
    radio_state = 3'd1;
    sel(1'b0); put(8'h7F); put(8'h01); put(8'h02); put(8'h03); sel(1'b1);
    radio_push(8'h10);
    radio_push(8'h20);
    @(negedge clk);
    radio_sleep = 1'b1;
    @(negedge clk);
    check("R11 tx cleared", tx_empty, 1);
    sel(1'b0); put(8'hBF);
    check("R11 rx cleared", status_cnt, 0);
    sel(1'b1);
    radio_sleep = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule